// File: doc/BRIEF.md
# Two-Core Semaphore Doorbell Controller

This peripheral lets two processor cores share a buffer safely and tell each other when it is their turn. It holds eight hardware semaphores. A core claims a semaphore with a read, which tells it whether it now holds the lock. It gives the lock back with a write. When a semaphore is given back, the controller raises a doorbell for the other core. It sets the status bit whose index is the semaphore number in the peer core's status register. If that core has enabled the bit, its level interrupt line goes high.

Each core has its own request port on a small register bus. The port a request arrives on identifies the requester. Each core also has a private status register, which is write-one-to-clear, and a private enable mask. Read data comes back one cycle after the request. The interrupt handler of the woken core clears its status bit so that the line drops before interrupts are enabled again.

Top module: `ipc_doorbell_sem`

## Requirements
- R1: After reset every semaphore is free, both status and both enable registers read zero, and both interrupt lines are low.
- R2: A read of address 0..7 claims semaphore n = address. If the semaphore was free, the read returns 1 in bit 0 and the reader becomes owner. If the other core holds it, the read returns 0.
- R3: A claim read by the core that already owns the semaphore returns 1 and leaves it owned by that core.
- R4: A write of any data to address 0..7 by the owning core frees that semaphore, so a later claim by either core succeeds. It also sets bit n in the other core's status register.
- R5: A write to a semaphore address by a core that does not own it changes nothing: the semaphore stays held and no status bit is set.
- R6: A release by core 0 sets status and drives line irq[1] (core 1). A release by core 1 sets status and drives line irq[0] (core 0).
- R7: irq[k] is high exactly when core k's status and enable registers share a set bit. A status bit whose enable bit is 0 raises no interrupt.
- R8: Writing to address 8 clears the requester's status bits that are 1 in the write data and leaves the others. The interrupt falls in the cycle right after the clearing write.
- R9: When both cores claim the same free semaphore in the same cycle, core 0 receives 1 and becomes owner, and core 1 receives 0.
- R10: Address 8 reads the requester's status and address 9 reads and writes its enable mask. Read data appears one cycle after the request. Other addresses read 0 and ignore writes.
- R11: When a release sets a status bit in the same cycle that the owner of that status register clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Request strobe per core (bit c = core c) |
| req_write | input | 2 | 1 = write, 0 = read, per core |
| req_addr | input | 8 | Register address, 4 bits per core, core c at [4c+3:4c] |
| req_wdata | input | 16 | Write data, 8 bits per core, core c at [8c+7:8c] |
| rsp_rdata | output | 16 | Read data one cycle after a read, 8 bits per core |
| irq | output | 2 | Level interrupt request per core |

## Verification
The bench targets the cases where ownership and doorbells are easy to get wrong. A release written by the core that does not own the semaphore must neither free it nor ring the peer. A design that skipped the owner check would hand the lock to the waiting core and set a spurious status bit. Two claims of one free semaphore in the same cycle must grant exactly one core. A design without priority would report success to both, or to core 1. The bench also checks that a clear arriving in the same cycle as a fresh release keeps the new bit, which a clear-first design would lose. It checks that the interrupt is gated by the enable mask, that it is steered to the peer line and not the releasing core's own line, and that it falls one cycle after the clear.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;

    localparam int NUM_CORES = 2;
    localparam int NUM_SEMS  = 8;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = $clog2(NUM_SEMS);
    localparam int ADDR_W    = IDX_W + 1;
    localparam int CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(NUM_SEMS);
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(NUM_SEMS + 1);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SEM,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic bus_req_t decode_req(
        input logic              valid,
        input logic              write,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] wdata
    );
        bus_req_t r;
        r       = '0;
        r.wdata = wdata;
        r.idx   = addr[IDX_W-1:0];
        r.rd    = valid && !write;
        r.wr    = valid && write;
        if (!addr[ADDR_W-1])
            r.sel = SEL_SEM;
        else if (addr == ADDR_STATUS)
            r.sel = SEL_STATUS;
        else if (addr == ADDR_ENABLE)
            r.sel = SEL_ENABLE;
        else
            r.sel = SEL_NONE;
        return r;
    endfunction

    function automatic int peer_of(input int c);
        return NUM_CORES - 1 - c;
    endfunction

endpackage

// File: rtl/ipc_sem_bank.sv
module ipc_sem_bank
    import ipc_db_pkg::*;
#(
    parameter int NC   = NUM_CORES,
    parameter int NSEM = NUM_SEMS,
    parameter int IW   = IDX_W,
    parameter int CW   = CID_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NC-1:0]           claim,
    input  logic [NC-1:0][IW-1:0]   claim_idx,
    input  logic [NC-1:0]           rel,
    input  logic [NC-1:0][IW-1:0]   rel_idx,
    output logic [NC-1:0]           grant,
    output logic [NC-1:0][NSEM-1:0] rel_done,
    output logic [NSEM-1:0]         busy,
    output logic [NSEM-1:0][CW-1:0] owner
);

    logic [NC-1:0][NSEM-1:0] take;

    always_comb begin
        grant    = '0;
        take     = '0;
        rel_done = '0;
        for (int s = 0; s < NSEM; s++) begin
            logic lower_claim;
            lower_claim = 1'b0;
            for (int c = 0; c < NC; c++) begin
                logic hit;
                hit = claim[c] && (claim_idx[c] == IW'(s));
                if (hit) begin
                    if (busy[s])
                        grant[c] = grant[c] | (owner[s] == CW'(c));
                    else if (!lower_claim) begin
                        grant[c]   = 1'b1;
                        take[c][s] = 1'b1;
                    end
                end
                lower_claim = lower_claim | hit;
                rel_done[c][s] = rel[c] && (rel_idx[c] == IW'(s)) &&
                                 busy[s] && (owner[s] == CW'(c));
            end
        end
    end

    for (genvar s = 0; s < NSEM; s++) begin : g_sem
        logic freed;
        always_comb begin
            freed = 1'b0;
            for (int c = 0; c < NC; c++) freed = freed | rel_done[c][s];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                busy[s]  <= 1'b0;
                owner[s] <= '0;
            end else if (freed) begin
                busy[s] <= 1'b0;
            end else begin
                for (int c = NC - 1; c >= 0; c--) begin
                    if (take[c][s]) begin
                        busy[s]  <= 1'b1;
                        owner[s] <= CW'(c);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ipc_irq_regs.sv
module ipc_irq_regs
    import ipc_db_pkg::*;
#(
    parameter int NC   = NUM_CORES,
    parameter int NSEM = NUM_SEMS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NC-1:0][NSEM-1:0] set_mask,
    input  logic [NC-1:0][NSEM-1:0] clr_mask,
    input  logic [NC-1:0]           en_we,
    input  logic [NC-1:0][NSEM-1:0] en_wdata,
    output logic [NC-1:0][NSEM-1:0] status,
    output logic [NC-1:0][NSEM-1:0] enable,
    output logic [NC-1:0]           irq
);

    for (genvar k = 0; k < NC; k++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst) begin
                status[k] <= '0;
                enable[k] <= '0;
            end else begin
                // a new event outranks a clear of the same bit
                status[k] <= (status[k] & ~clr_mask[k]) | set_mask[k];
                if (en_we[k])
                    enable[k] <= en_wdata[k];
            end
        end

        assign irq[k] = |(status[k] & enable[k]);
    end

endmodule

// File: rtl/ipc_doorbell_sem.sv
module ipc_doorbell_sem
    import ipc_db_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [NUM_CORES-1:0]          req_write,
    input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
    output logic [NUM_CORES*DATA_W-1:0]   rsp_rdata,
    output logic [NUM_CORES-1:0]          irq
);

    bus_req_t [NUM_CORES-1:0]                 req;
    logic [NUM_CORES-1:0]                     claim, rel, grant, en_we;
    logic [NUM_CORES-1:0][IDX_W-1:0]          sem_idx;
    logic [NUM_CORES-1:0][NUM_SEMS-1:0]       rel_done, set_mask, clr_mask, en_wdata;
    logic [NUM_CORES-1:0][NUM_SEMS-1:0]       status, enable;
    logic [NUM_SEMS-1:0]                      sem_busy;
    logic [NUM_SEMS-1:0][CID_W-1:0]           sem_owner;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_port
        localparam int PEER = peer_of(c);

        always_comb begin
            req[c] = decode_req(req_valid[c], req_write[c],
                                req_addr[c*ADDR_W +: ADDR_W],
                                req_wdata[c*DATA_W +: DATA_W]);
        end

        assign claim[c]    = req[c].rd && (req[c].sel == SEL_SEM);
        assign rel[c]      = req[c].wr && (req[c].sel == SEL_SEM);
        assign sem_idx[c]  = req[c].idx;
        assign clr_mask[c] = (req[c].wr && req[c].sel == SEL_STATUS) ?
                             req[c].wdata[NUM_SEMS-1:0] : '0;
        assign en_we[c]    = req[c].wr && (req[c].sel == SEL_ENABLE);
        assign en_wdata[c] = req[c].wdata[NUM_SEMS-1:0];
        assign set_mask[c] = rel_done[PEER];

        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_rdata[c*DATA_W +: DATA_W] <= '0;
            end else if (req[c].rd) begin
                unique case (req[c].sel)
                    SEL_SEM:    rsp_rdata[c*DATA_W +: DATA_W] <= DATA_W'(grant[c]);
                    SEL_STATUS: rsp_rdata[c*DATA_W +: DATA_W] <= DATA_W'(status[c]);
                    SEL_ENABLE: rsp_rdata[c*DATA_W +: DATA_W] <= DATA_W'(enable[c]);
                    default:    rsp_rdata[c*DATA_W +: DATA_W] <= '0;
                endcase
            end
        end
    end

    ipc_sem_bank #(
        .NC   (NUM_CORES),
        .NSEM (NUM_SEMS),
        .IW   (IDX_W),
        .CW   (CID_W)
    ) sem_bank_i (
        .clk       (clk),
        .rst       (rst),
        .claim     (claim),
        .claim_idx (sem_idx),
        .rel       (rel),
        .rel_idx   (sem_idx),
        .grant     (grant),
        .rel_done  (rel_done),
        .busy      (sem_busy),
        .owner     (sem_owner)
    );

    ipc_irq_regs #(
        .NC   (NUM_CORES),
        .NSEM (NUM_SEMS)
    ) irq_regs_i (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

endmodule

// File: rtl/ipc_doorbell_sem_chk.sv
module ipc_doorbell_sem_chk
    import ipc_db_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CORES-1:0]          req_valid,
    input logic [NUM_CORES-1:0]          req_write,
    input logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input logic [NUM_CORES*DATA_W-1:0]   req_wdata,
    input logic [NUM_CORES*DATA_W-1:0]   rsp_rdata,
    input logic [NUM_CORES-1:0]          irq,
    input logic [NUM_SEMS-1:0]           sem_busy,
    input logic [NUM_SEMS-1:0][CID_W-1:0] sem_owner
);

    // R1: leaving reset, outputs are quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0) && (rsp_rdata == '0));

    // R9: two same-cycle claims of one semaphore never both succeed
    assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid == 2'b11 && req_write == 2'b00 &&
         req_addr[ADDR_W-1:0] == req_addr[2*ADDR_W-1:ADDR_W] && !req_addr[ADDR_W-1])
        |=> !(rsp_rdata[0] && rsp_rdata[DATA_W]));

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_line
        localparam int P = peer_of(k);

        // R6: a line only rises after a peer semaphore write or own enable write
        assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[k]) |->
                $past(req_valid[P] && req_write[P] && !req_addr[P*ADDR_W + ADDR_W - 1]) ||
                $past(req_valid[k] && req_write[k] &&
                      req_addr[k*ADDR_W +: ADDR_W] == ADDR_ENABLE));

        // R8: clearing every status bit drops the line next cycle
        assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
            (req_valid[k] && req_write[k] &&
             req_addr[k*ADDR_W +: ADDR_W] == ADDR_STATUS &&
             req_wdata[k*DATA_W +: NUM_SEMS] == '1 &&
             !(req_valid[P] && req_write[P] && !req_addr[P*ADDR_W + ADDR_W - 1]))
            |=> !irq[k]);

        for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
            // R5: a non-owner write keeps the lock with its owner
            assert_nonowner_ignored_R5: assert property (@(posedge clk) disable iff (rst)
                (req_valid[k] && req_write[k] &&
                 req_addr[k*ADDR_W +: ADDR_W] == ADDR_W'(s) &&
                 sem_busy[s] && sem_owner[s] != CID_W'(k) &&
                 !(req_valid[P] && req_write[P] && req_addr[P*ADDR_W +: ADDR_W] == ADDR_W'(s)))
                |=> sem_busy[s] && $stable(sem_owner[s]));
        end
    end

endmodule

bind ipc_doorbell_sem ipc_doorbell_sem_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .sem_busy  (sem_busy),
    .sem_owner (sem_owner)
);

// File: tb/ipc_doorbell_sem_tb.sv
module ipc_doorbell_sem_tb_top;
    import ipc_db_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NUM_CORES-1:0]        req_valid = '0;
    logic [NUM_CORES-1:0]        req_write = '0;
    logic [NUM_CORES*ADDR_W-1:0] req_addr  = '0;
    logic [NUM_CORES*DATA_W-1:0] req_wdata = '0;
    logic [NUM_CORES*DATA_W-1:0] rsp_rdata;
    logic [NUM_CORES-1:0]        irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_doorbell_sem dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // one request on one core port; returns that core's read data
    task automatic bus(input int c, input bit wr, input int addr, input int wdata,
                       output int rdata);
        @(negedge clk);
        req_valid[c] = 1'b1;
        req_write[c] = wr;
        req_addr[c*ADDR_W +: ADDR_W] = ADDR_W'(addr);
        req_wdata[c*DATA_W +: DATA_W] = DATA_W'(wdata);
        @(negedge clk);
        req_valid = '0;
        rdata = int'(rsp_rdata[c*DATA_W +: DATA_W]);
    endtask

    task automatic bus_both(input bit wr0, input int a0, input int d0,
                            input bit wr1, input int a1, input int d1,
                            output int r0, output int r1);
        @(negedge clk);
        req_valid = 2'b11;
        req_write = {wr1, wr0};
        req_addr  = {ADDR_W'(a1), ADDR_W'(a0)};
        req_wdata = {DATA_W'(d1), DATA_W'(d0)};
        @(negedge clk);
        req_valid = '0;
        r0 = int'(rsp_rdata[DATA_W-1:0]);
        r1 = int'(rsp_rdata[2*DATA_W-1:DATA_W]);
    endtask

    task automatic t_reset();
        int r;
        check_eq("R1 irq after reset", int'(irq), 0);
        bus(0, 0, 8, 0, r); check_eq("R1 core0 status", r, 0);
        bus(1, 0, 8, 0, r); check_eq("R1 core1 status", r, 0);
        bus(0, 0, 9, 0, r); check_eq("R1 core0 enable", r, 0);
        bus(1, 0, 9, 0, r); check_eq("R1 core1 enable", r, 0);
        bus(1, 0, 15, 0, r); check_eq("R10 unmapped read", r, 0);
    endtask

    task automatic t_claim();
        int r;
        bus(0, 0, 3, 0, r); check_eq("R2 core0 claims free sem3", r, 1);
        bus(1, 0, 3, 0, r); check_eq("R2 core1 claim of held sem3", r, 0);
        bus(0, 0, 3, 0, r); check_eq("R3 owner re-claim sem3", r, 1);
    endtask

    task automatic t_nonowner();
        int r;
        bus(1, 1, 3, 8'hFF, r);
        check_eq("R5 irq after non-owner release", int'(irq), 0);
        bus(0, 0, 8, 0, r); check_eq("R5 core0 status untouched", r, 0);
        bus(1, 0, 3, 0, r); check_eq("R5 sem3 still held", r, 0);
    endtask

    task automatic t_release();
        int r;
        bus(1, 1, 9, 8'hFF, r);
        bus(1, 0, 9, 0, r); check_eq("R10 core1 enable readback", r, 8'hFF);
        bus(0, 1, 3, 0, r);
        check_eq("R6 core0 release drives line 1", int'(irq), 2);
        bus(1, 0, 8, 0, r); check_eq("R4 core1 status bit3", r, 8'h08);
        bus(0, 0, 8, 0, r); check_eq("R6 core0 status stays clear", r, 0);
        bus(1, 0, 3, 0, r); check_eq("R4 sem3 free for core1", r, 1);
    endtask

    task automatic t_clear();
        int r;
        bus(0, 0, 0, 0, r); check_eq("R2 core0 claims sem0", r, 1);
        bus(0, 1, 0, 0, r);
        bus(1, 0, 8, 0, r); check_eq("R4 core1 status bits 3,0", r, 8'h09);
        bus(1, 1, 8, 8'h01, r);
        check_eq("R8 partial clear keeps irq", int'(irq), 2);
        bus(1, 0, 8, 0, r); check_eq("R8 partial clear leaves bit3", r, 8'h08);
        bus(1, 1, 8, 8'h08, r);
        check_eq("R8 irq low cycle after clear", int'(irq), 0);
    endtask

    task automatic t_mask();
        int r;
        bus(1, 1, 3, 0, r);
        check_eq("R7 masked status raises no irq", int'(irq), 0);
        bus(0, 0, 8, 0, r); check_eq("R6 core1 release sets core0 bit3", r, 8'h08);
        bus(0, 1, 9, 8'h08, r);
        check_eq("R7 enabling bit raises line 0", int'(irq), 1);
        bus(0, 1, 10, 8'hFF, r);
        bus(0, 0, 9, 0, r); check_eq("R10 unmapped write ignored", r, 8'h08);
        bus(0, 1, 8, 8'hFF, r);
        check_eq("R8 line 0 drops after clear", int'(irq), 0);
    endtask

    task automatic t_race();
        int r0, r1;
        bus_both(0, 6, 0, 0, 6, 0, r0, r1);
        check_eq("R9 core0 wins same-cycle claim", r0, 1);
        check_eq("R9 core1 loses same-cycle claim", r1, 0);
        bus(1, 0, 6, 0, r0); check_eq("R9 sem6 owned by core0", r0, 0);
    endtask

    task automatic t_set_clr();
        int r0, r1;
        bus_both(1, 6, 0, 1, 8, 8'h40, r0, r1);
        check_eq("R11 irq after set+clear collision", int'(irq), 2);
        bus(1, 0, 8, 0, r1); check_eq("R11 set wins over clear", r1, 8'h40);
        bus(1, 1, 8, 8'h40, r1);
        check_eq("R8 final clear", int'(irq), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_claim();
        t_nonowner();
        t_release();
        t_clear();
        t_mask();
        t_race();
        t_set_clr();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule